// File: doc/BRIEF.md
# Two-Core Cascaded Interrupt Router

This block gathers 64 level-sensitive request lines, arranged as a low bank and a high bank of 32 lines each, and turns them into one normal interrupt and one fast interrupt for each of two processor cores. Each line's status is the OR of its source input and a software-forced bit. For every bank, each core keeps its own enable mask and its own fast-path select mask. An enabled line drives the core's fast interrupt when its select bit is set. Otherwise it drives the core's normal interrupt.

The high bank never drives a core output directly. For each core, its enabled active high-bank lines are OR-ed into one summary bit. That bit is injected into line 30 of the same core's low-bank view, where the core's low-bank enable and select bits for line 30 route it. Software reaches every mask and status word through a flat single-cycle register bus. Writes take effect at the clock edge and reads are combinational.

The block holds no state machine. Its only state is the enable, select and forced registers of each bank, and every output is a combinational function of those registers and the live source lines.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, all enable masks, fast-path select masks and forced bits are zero, so `core_irq` and `core_fiq` are low whatever the sources do.
- R2: Per bank and core, writing ones to the enable-set word (offset 4 for core 0, 8 for core 1) sets those enable bits. Writing ones to the enable-clear word (offset 5 / 9) clears them. The enable word (offset 6 / 10) reads the current mask. Bits written as zero, the other core's mask and the other bank's masks are left unchanged.
- R3: Writing ones to the force-set word (offset 1) sets forced bits, and writing ones to force-clear (offset 2) clears them. The forced word (offset 3) reads them back. The raw word (offset 0) reads source OR forced, without the cascade bit.
- R4: For core c, `core_irq[c]` is the OR over low-bank lines of (status AND enable AND NOT select), and `core_fiq[c]` uses select in place of NOT select. A source change shows at the outputs in the same cycle. A register write shows in the cycle after the write edge.
- R5: For each bank and core, the masked normal-status word (offset 12 / 14) and the masked fast-status word (offset 13 / 15) report the per-line terms of R4. In the low bank these include the cascade bit at line 30.
- R6: For core c, low-bank line 30 is additionally asserted when any high-bank line is active and enabled in core c's high-bank mask. One core's high-bank enables never reach the other core.
- R7: Source bit positions are fixed. Low bank: timer 1 at 0, timer 2 at 1, mailbox at 4, audio serial at 10, disk at 23, USB at 24. High bank: GPIO at 0, I2C at 8.
- R8: Address bit 4 selects the bank (0 low, 1 high) and bits 3:0 select the offset. Writes to read-only offsets (0, 3, 6, 10, 12 to 15) change nothing. Write-only offsets (1, 2, 4, 5, 8, 9) read as zero.
- R9: The select word (offset 7 / 11) is read-write. A low-bank select of all ones moves every enabled line of that core to `core_fiq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo | input | 32 | Low-bank request lines, level-sensitive |
| src_hi | input | 32 | High-bank request lines, level-sensitive |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Bank select (bit 4) and register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| core_irq | output | 2 | Normal interrupt per core |
| core_fiq | output | 2 | Fast interrupt per core |

## Verification
Source and address changes reach `core_irq`, `core_fiq` and `bus_rdata` with no register in the path, so the bench drives them on a falling edge and samples one time step later in the same low phase. A register write is held over one rising edge and then released on the next falling edge. Its effect is sampled after that release, which is the first point where the new mask or forced value can be seen. Cascade checks follow the same timing, because the high-bank summary is combinational into the low-bank view.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int LINES        = 32;
    parameter int NCORES       = 2;
    parameter int CASCADE_LINE = 30;

    // fixed source positions
    parameter int LO_TIMER1  = 0;
    parameter int LO_TIMER2  = 1;
    parameter int LO_MAILBOX = 4;
    parameter int LO_AUDIO   = 10;
    parameter int LO_DISK    = 23;
    parameter int LO_USB     = 24;
    parameter int HI_GPIO    = 0;
    parameter int HI_I2C     = 8;

    // register offsets inside one bank
    parameter int OFF_RAW    = 0;
    parameter int OFF_FSET   = 1;
    parameter int OFF_FCLR   = 2;
    parameter int OFF_FORCED = 3;

    function automatic int off_en_set(input int c);
        return 4 + 4 * c;
    endfunction
    function automatic int off_en_clr(input int c);
        return 5 + 4 * c;
    endfunction
    function automatic int off_en_rd(input int c);
        return 6 + 4 * c;
    endfunction
    function automatic int off_fsel(input int c);
        return 7 + 4 * c;
    endfunction
    function automatic int off_irq_stat(input int c, input int nc);
        return 4 + 4 * nc + 2 * c;
    endfunction
    function automatic int off_fiq_stat(input int c, input int nc);
        return 5 + 4 * nc + 2 * c;
    endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int N     = LINES,
    parameter int NC    = NCORES,
    parameter int OFF_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          src,
    input  logic [NC-1:0][N-1:0]  inject,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      off,
    input  logic [N-1:0]          wdata,
    output logic [N-1:0]          rdata,
    output logic [NC-1:0][N-1:0]  irq_stat,
    output logic [NC-1:0][N-1:0]  fiq_stat
);
    logic [N-1:0]         forced_q;
    logic [NC-1:0][N-1:0] en_q;
    logic [NC-1:0][N-1:0] fsel_q;
    logic [N-1:0]         raw;

    assign raw = src | forced_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            forced_q <= '0;
            en_q     <= '0;
            fsel_q   <= '0;
        end else if (wr_en) begin
            if (int'(off) == OFF_FSET) forced_q <= forced_q | wdata;
            if (int'(off) == OFF_FCLR) forced_q <= forced_q & ~wdata;
            for (int c = 0; c < NC; c++) begin
                if (int'(off) == off_en_set(c)) en_q[c]   <= en_q[c] | wdata;
                if (int'(off) == off_en_clr(c)) en_q[c]   <= en_q[c] & ~wdata;
                if (int'(off) == off_fsel(c))   fsel_q[c] <= wdata;
            end
        end
    end

    generate
        for (genvar g = 0; g < NC; g++) begin : g_core
            logic [N-1:0] eff;
            assign eff         = raw | inject[g];
            assign irq_stat[g] = eff & en_q[g] & ~fsel_q[g];
            assign fiq_stat[g] = eff & en_q[g] & fsel_q[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (int'(off) == OFF_RAW)    rdata = raw;
        if (int'(off) == OFF_FORCED) rdata = forced_q;
        for (int c = 0; c < NC; c++) begin
            if (int'(off) == off_en_rd(c))         rdata = en_q[c];
            if (int'(off) == off_fsel(c))          rdata = fsel_q[c];
            if (int'(off) == off_irq_stat(c, NC))  rdata = irq_stat[c];
            if (int'(off) == off_fiq_stat(c, NC))  rdata = fiq_stat[c];
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter int N  = LINES,
    parameter int NC = NCORES,
    parameter int CL = CASCADE_LINE,
    localparam int OFF_W  = $clog2(4 + 6 * NC),
    localparam int ADDR_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_lo,
    input  logic [N-1:0]      src_hi,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic [NC-1:0]     core_irq,
    output logic [NC-1:0]     core_fiq
);
    logic                  sel_hi;
    logic [OFF_W-1:0]      off;
    logic [N-1:0]          lo_rd, hi_rd;
    logic [NC-1:0][N-1:0]  lo_irq_s, lo_fiq_s, hi_irq_s, hi_fiq_s;
    logic [NC-1:0][N-1:0]  lo_inject, hi_inject;

    assign sel_hi    = bus_addr[OFF_W];
    assign off       = bus_addr[OFF_W-1:0];
    assign hi_inject = '0;

    generate
        for (genvar g = 0; g < NC; g++) begin : g_casc
            logic summary;
            assign summary      = |(hi_irq_s[g] | hi_fiq_s[g]);
            assign lo_inject[g] = N'(summary) << CL;
            assign core_irq[g]  = |lo_irq_s[g];
            assign core_fiq[g]  = |lo_fiq_s[g];
        end
    endgenerate

    irqc_bank #(.N(N), .NC(NC), .OFF_W(OFF_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .src(src_lo), .inject(lo_inject),
        .wr_en(bus_wr && !sel_hi), .off(off), .wdata(bus_wdata),
        .rdata(lo_rd), .irq_stat(lo_irq_s), .fiq_stat(lo_fiq_s)
    );

    irqc_bank #(.N(N), .NC(NC), .OFF_W(OFF_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .src(src_hi), .inject(hi_inject),
        .wr_en(bus_wr && sel_hi), .off(off), .wdata(bus_wdata),
        .rdata(hi_rd), .irq_stat(hi_irq_s), .fiq_stat(hi_fiq_s)
    );

    assign bus_rdata = sel_hi ? hi_rd : lo_rd;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N  = LINES,
    parameter int NC = NCORES,
    localparam int OFF_W  = $clog2(4 + 6 * NC),
    localparam int ADDR_W = OFF_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      src_lo,
    input logic [N-1:0]      src_hi,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      bus_rdata,
    input logic [NC-1:0]     core_irq,
    input logic [NC-1:0]     core_fiq
);
    generate
        for (genvar g = 0; g < NC; g++) begin : g_chk
            localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(off_en_clr(g));
            localparam logic [ADDR_W-1:0] A_FSEL = ADDR_W'(off_fsel(g));
            localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(off_irq_stat(g, NC));
            localparam logic [ADDR_W-1:0] A_FST  = ADDR_W'(off_fiq_stat(g, NC));

            // R2: clearing every low-bank enable silences both outputs
            a_r2_clear_all_silences: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == A_CLR && bus_wdata == '1) |=> (!core_irq[g] && !core_fiq[g]));

            // R9: an all-ones low-bank select leaves nothing on the normal path
            a_r9_fsel_all_to_fiq: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == A_FSEL && bus_wdata == '1) |=> !core_irq[g]);

            // R5: low-bank normal status word agrees with the core output
            a_r5_irq_stat_matches: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_addr == A_IST) |-> ((|bus_rdata) == core_irq[g]));

            // R5: low-bank fast status word agrees with the core output
            a_r5_fiq_stat_matches: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_addr == A_FST) |-> ((|bus_rdata) == core_fiq[g]));
        end
    endgenerate
endmodule

bind irq_cascade_ctrl irqc_checker #(.N(N), .NC(NC)) u_chk (.*);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;
    import irqc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lo = '0, src_hi = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  core_irq, core_fiq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_cascade_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    function automatic logic [4:0] ad(input bit hi, input int o);
        return {hi, 4'(o)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        src_lo = '1; src_hi = '1; #1;
        check("R1 irq in reset state", {30'b0, core_irq}, 32'h0);
        check("R1 fiq in reset state", {30'b0, core_fiq}, 32'h0);
        rd(ad(0, off_en_rd(0)), d);  check("R1 low enable core0", d, 32'h0);
        rd(ad(0, OFF_FORCED), d);    check("R1 forced", d, 32'h0);
        rd(ad(1, off_fsel(1)), d);   check("R1 high select core1", d, 32'h0);
        src_lo = '0; src_hi = '0; #1;
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(ad(0, off_en_set(0)), (32'h1 << LO_TIMER1) | (32'h1 << LO_TIMER2) | (32'h1 << LO_MAILBOX));
        rd(ad(0, off_en_rd(0)), d); check("R2 enable set core0", d, 32'h13);
        rd(ad(0, off_en_rd(1)), d); check("R2 core1 untouched", d, 32'h0);
        rd(ad(1, off_en_rd(0)), d); check("R2 high bank untouched", d, 32'h0);
        wr(ad(0, off_en_clr(0)), 32'h1 << LO_TIMER2);
        rd(ad(0, off_en_rd(0)), d); check("R2 enable clear core0", d, 32'h11);
    endtask

    task automatic t_route();
        logic [31:0] d;
        src_lo = 32'h1 << LO_TIMER2; #1;
        check("R4 disabled line gives no irq", {30'b0, core_irq}, 32'h0);
        src_lo = 32'h1 << LO_TIMER1; #1;
        check("R7 R4 timer1 irq core0 only", {30'b0, core_irq}, 32'h1);
        check("R4 no fiq", {30'b0, core_fiq}, 32'h0);
        wr(ad(0, off_fsel(0)), 32'h1 << LO_TIMER1);
        check("R4 selected line leaves irq", {30'b0, core_irq}, 32'h0);
        check("R4 selected line drives fiq", {30'b0, core_fiq}, 32'h1);
        rd(ad(0, off_fsel(0)), d);         check("R9 select readback", d, 32'h1);
        rd(ad(0, off_fiq_stat(0, 2)), d);  check("R5 low fiq status core0", d, 32'h1);
        rd(ad(0, off_irq_stat(0, 2)), d);  check("R5 low irq status core0", d, 32'h0);
        src_lo = '0; #1;
        check("R4 level drop clears fiq", {30'b0, core_fiq}, 32'h0);
        wr(ad(0, off_fsel(0)), 32'h0);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(ad(0, OFF_FSET), 32'h1 << LO_AUDIO);
        rd(ad(0, OFF_FORCED), d); check("R3 forced readback", d, 32'h400);
        rd(ad(0, OFF_RAW), d);    check("R3 raw includes forced", d, 32'h400);
        check("R3 forced but not enabled", {30'b0, core_irq}, 32'h0);
        wr(ad(0, off_en_set(1)), 32'h1 << LO_AUDIO);
        check("R3 forced line irq core1", {30'b0, core_irq}, 32'h2);
        rd(ad(0, off_irq_stat(1, 2)), d); check("R5 low irq status core1", d, 32'h400);
        wr(ad(0, OFF_FCLR), 32'h1 << LO_AUDIO);
        check("R3 force clear drops irq", {30'b0, core_irq}, 32'h0);
        rd(ad(0, OFF_RAW), d); check("R3 raw after clear", d, 32'h0);
    endtask

    task automatic t_cascade();
        logic [31:0] d;
        wr(ad(1, off_en_set(0)), 32'h1 << HI_I2C);
        src_hi = 32'h1 << HI_I2C; #1;
        check("R6 cascade blocked by low enable", {30'b0, core_irq}, 32'h0);
        rd(ad(1, off_irq_stat(0, 2)), d); check("R5 high irq status core0", d, 32'h100);
        wr(ad(0, off_en_set(0)), 32'h1 << CASCADE_LINE);
        check("R6 cascade reaches core0", {30'b0, core_irq}, 32'h1);
        rd(ad(0, off_irq_stat(0, 2)), d); check("R6 cascade bit in low status", d, 32'h4000_0000);
        wr(ad(0, off_en_set(1)), 32'h1 << CASCADE_LINE);
        check("R6 core1 not reached by core0 high enable", {30'b0, core_irq}, 32'h1);
        rd(ad(0, OFF_RAW), d); check("R3 raw excludes cascade", d, 32'h0);
        src_hi = 32'h1 << HI_GPIO; #1;
        check("R7 gpio line not enabled", {30'b0, core_irq}, 32'h0);
        src_hi = '0; #1;
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(ad(0, OFF_RAW), 32'hFFFF_FFFF);
        rd(ad(0, OFF_RAW), d);             check("R8 raw ignores write", d, 32'h0);
        wr(ad(0, off_irq_stat(0, 2)), 32'hFFFF_FFFF);
        rd(ad(0, off_irq_stat(0, 2)), d);  check("R8 status ignores write", d, 32'h0);
        rd(ad(0, OFF_FSET), d);            check("R8 write-only reads zero", d, 32'h0);
        rd(ad(0, off_en_set(0)), d);       check("R8 enable-set reads zero", d, 32'h0);
        wr(ad(0, off_en_clr(0)), 32'hFFFF_FFFF);
        rd(ad(0, off_en_rd(0)), d);        check("R2 clear all core0", d, 32'h0);
        rd(ad(0, off_en_rd(1)), d);        check("R2 core1 kept", d, 32'h4000_0400);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_enable();
        t_route();
        t_force();
        t_cascade();
        t_map();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule